// File: doc/BRIEF.md
# T1 Transmit Framing-Bit Generator with Error Injection

This block sits on the transmit side of a T1 line. It produces the framing bit for each 193-bit frame and conditions the 24 channel bytes that follow it. It supports two framing structures. The 12-frame superframe (D4) alternates terminal-framing and signalling-framing bits. The 24-frame extended superframe (ESF) places a pattern bit in every fourth frame. The data link, the CRC-6, line coding and serialisation are handled outside.

For line testing, the pattern-carrying framing bits can be deliberately inverted, either as a short burst of three or as a periodic single error. Channel bytes can be changed in three ways: an all-zero byte can have one bit forced high for ones density, the D4 yellow alarm can clear one payload bit in every byte, or the yellow alarm can instead be signalled on the last signalling-framing bit of the superframe. In D4 mode a host-supplied six-bit value can replace the internal signalling-framing sequence.

Top module: `t1_fbit_injector`

## Requirements
- R1: Each cycle with `frame_start` high advances the frame number, wrapping after frame 12 (D4, `esf_mode`=0) or frame 24 (ESF, `esf_mode`=1). After reset, or after any change of `esf_mode`, the next strobe starts frame 1. A strobe and a mode change in the same cycle also start frame 1. `fbit` takes the new frame's bit on the clock edge that samples the strobe and holds otherwise. After reset, `fbit`, `out_valid` and `out_data` are 0.
- R2: In D4 mode, frames 1,3,5,7,9,11 carry terminal-framing bits 1,0,1,0,1,0 in that order.
- R3: In D4 mode, frames 2,4,6,8,10,12 carry signalling-framing bits 0,0,1,1,1,0. While `fs_ins_en` is high in D4 mode, frame 2k+2 instead carries `fs_pattern[k]` (k = 0..5). `fs_ins_en` has no effect in ESF mode.
- R4: In ESF mode, frames 4,8,12,16,20,24 carry pattern bits 0,0,1,0,1,1, and every other frame outputs 0.
- R5: A rising edge of `burst_ctl` inverts the next three pattern bits (terminal-framing bits in D4, every-fourth-frame bits in ESF). A strobe sampled in the same cycle as the edge counts as the first of the three. A new rising edge during a burst restarts the count at three. Signalling-framing bits and ESF non-pattern frames are never inverted.
- R6: While `period_ctl` is high, the first pattern bit after it goes high is inverted, and then every PERIOD-th pattern bit after that (PERIOD defaults to 128). Clearing `period_ctl` resets the count.
- R7: When both the burst and the periodic mechanism hit the same pattern bit, that bit is inverted exactly once, so the frame carries its normal value with a single inversion.
- R8: While `zs_en` is high, a byte that is all zero after any yellow-alarm change is sent as 8'h02 (channel bit 7, the second least significant bit, is set). While `zs_en` is low and no yellow change applies, bytes pass through unchanged.
- R9: In D4 mode with `yel_en`=1 and `yel_fs_style`=0, channel bit 2 (mask 8'h40, the second most significant bit) is cleared in every byte.
- R10: In D4 mode with `yel_en`=1 and `yel_fs_style`=1, the frame-12 framing bit is 1, overriding both the internal sequence and `fs_pattern`, and bytes are unchanged. `yel_en` has no effect on either bits or bytes in ESF mode.
- R11: `out_valid` equals `ch_valid` delayed by one clock, and `out_data` carries the processed byte in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| ch_valid | input | 1 | Channel byte valid |
| ch_data | input | 8 | Channel byte, MSB is channel bit 1 |
| esf_mode | input | 1 | 0 = D4 superframe, 1 = ESF |
| zs_en | input | 1 | Bit-7 zero suppression enable |
| yel_en | input | 1 | D4 yellow alarm active |
| yel_fs_style | input | 1 | Yellow style: 0 = clear bit 2 in bytes, 1 = frame-12 framing bit high |
| fs_ins_en | input | 1 | Use `fs_pattern` for D4 signalling-framing bits |
| fs_pattern | input | 6 | Host signalling-framing bits, bit k for frame 2k+2 |
| burst_ctl | input | 1 | Rising edge starts a three-bit corruption burst |
| period_ctl | input | 1 | High enables one inversion per PERIOD pattern bits |
| fbit | output | 1 | Framing bit of the current frame |
| out_valid | output | 1 | Processed byte valid |
| out_data | output | 8 | Processed channel byte |

## Verification
The bench builds the block with PERIOD set to 16 and BURST_LEN left at three. The periodic-error counter then wraps many times in both D4 and ESF within a short run, so every-PERIOD spacing, clearing mid-count and collisions with a burst are all observed. The bench switches modes in the middle of a superframe to exercise the restart to frame 1. It also restarts a burst while one is in progress, and it feeds 8'h40 bytes so that the yellow mask and zero suppression interact.

// File: rtl/t1fb_pkg.sv
package t1fb_pkg;
    localparam int D4_FRAMES  = 12;
    localparam int ESF_FRAMES = 24;
    localparam int IDX_W      = $clog2(ESF_FRAMES);
    localparam int BYTE_W     = 8;
    // channel bit n (1 = MSB) sits at vector index BYTE_W-n
    localparam int BIT2_POS   = BYTE_W - 2;
    localparam int BIT7_POS   = BYTE_W - 7;
    // bit k of each sequence belongs to the k-th carrying frame
    localparam logic [5:0] FS_SEQ  = 6'b011100;
    localparam logic [5:0] FPS_SEQ = 6'b110100;

    typedef logic [IDX_W-1:0] idx_t;

    function automatic idx_t last_idx(input logic esf);
        return esf ? idx_t'(ESF_FRAMES - 1) : idx_t'(D4_FRAMES - 1);
    endfunction
endpackage

// File: rtl/t1fb_seq.sv
module t1fb_seq
    import t1fb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic esf_mode,
    output idx_t idx_nxt
);
    typedef struct packed {
        idx_t idx;
        logic esf;
    } seq_st_t;

    seq_st_t st_d, st_q;
    idx_t    base;

    always_comb begin
        st_d     = st_q;
        st_d.esf = esf_mode;
        base     = (esf_mode != st_q.esf) ? last_idx(esf_mode) : st_q.idx;
        if (frame_start) begin
            st_d.idx = (base == last_idx(esf_mode)) ? '0 : base + 1'b1;
        end else begin
            st_d.idx = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idx <= last_idx(1'b0);
            st_q.esf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_nxt = st_d.idx;
endmodule

// File: rtl/t1fb_corrupt.sv
module t1fb_corrupt #(
    parameter int PERIOD    = 128,
    parameter int BURST_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pat_stb,
    input  logic burst_ctl,
    input  logic period_ctl,
    output logic invert
);
    localparam int PC_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int BL_W = $clog2(BURST_LEN + 1);

    typedef struct packed {
        logic            burst_prev;
        logic [BL_W-1:0] left;
        logic [PC_W-1:0] pcnt;
    } cor_st_t;

    cor_st_t         st_d, st_q;
    logic [BL_W-1:0] left_eff;
    logic            hit_b, hit_p;

    always_comb begin
        st_d            = st_q;
        st_d.burst_prev = burst_ctl;
        left_eff        = (burst_ctl && !st_q.burst_prev) ? BL_W'(BURST_LEN) : st_q.left;
        hit_b           = pat_stb && (left_eff != '0);
        st_d.left       = hit_b ? left_eff - 1'b1 : left_eff;
        hit_p           = 1'b0;
        if (!period_ctl) begin
            st_d.pcnt = '0;
        end else if (pat_stb) begin
            hit_p     = (st_q.pcnt == '0);
            st_d.pcnt = (st_q.pcnt == PC_W'(PERIOD - 1)) ? '0 : st_q.pcnt + 1'b1;
        end
        invert = hit_b | hit_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/t1fb_chan.sv
module t1fb_chan
    import t1fb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_valid,
    input  logic [BYTE_W-1:0] ch_data,
    input  logic              clr_bit2,
    input  logic              zs_en,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);
    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } chan_st_t;

    chan_st_t          st_d, st_q;
    logic [BYTE_W-1:0] masked;

    always_comb begin
        st_d     = st_q;
        st_d.vld = ch_valid;
        masked   = ch_data;
        if (clr_bit2) masked[BIT2_POS] = 1'b0;
        if (zs_en && (masked == '0)) masked[BIT7_POS] = 1'b1;
        if (ch_valid) st_d.data = masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
endmodule

// File: rtl/t1_fbit_injector.sv
module t1_fbit_injector
    import t1fb_pkg::*;
#(
    parameter int PERIOD    = 128,
    parameter int BURST_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       ch_valid,
    input  logic [7:0] ch_data,
    input  logic       esf_mode,
    input  logic       zs_en,
    input  logic       yel_en,
    input  logic       yel_fs_style,
    input  logic       fs_ins_en,
    input  logic [5:0] fs_pattern,
    input  logic       burst_ctl,
    input  logic       period_ctl,
    output logic       fbit,
    output logic       out_valid,
    output logic [7:0] out_data
);
    typedef struct packed {
        logic fbit;
    } top_st_t;

    top_st_t    st_d, st_q;
    idx_t       idx_nxt;
    logic       is_pat, pat_stb, invert, base_bit;
    logic [2:0] k;

    t1fb_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .esf_mode    (esf_mode),
        .idx_nxt     (idx_nxt)
    );

    t1fb_corrupt #(
        .PERIOD    (PERIOD),
        .BURST_LEN (BURST_LEN)
    ) u_cor (
        .clk        (clk),
        .rst_n      (rst_n),
        .pat_stb    (pat_stb),
        .burst_ctl  (burst_ctl),
        .period_ctl (period_ctl),
        .invert     (invert)
    );

    t1fb_chan u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_valid  (ch_valid),
        .ch_data   (ch_data),
        .clr_bit2  (yel_en && !esf_mode && !yel_fs_style),
        .zs_en     (zs_en),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always_comb begin
        st_d     = st_q;
        is_pat   = 1'b0;
        base_bit = 1'b0;
        k        = '0;
        if (!esf_mode) begin
            k = idx_nxt[3:1];
            if (!idx_nxt[0]) begin
                is_pat   = 1'b1;
                base_bit = ~idx_nxt[1];
            end else begin
                base_bit = fs_ins_en ? fs_pattern[k] : FS_SEQ[k];
                if (yel_en && yel_fs_style && (idx_nxt == idx_t'(D4_FRAMES - 1))) base_bit = 1'b1;
            end
        end else if (idx_nxt[1:0] == 2'b11) begin
            k        = idx_nxt[4:2];
            is_pat   = 1'b1;
            base_bit = FPS_SEQ[k];
        end
        pat_stb = frame_start && is_pat;
        if (frame_start) st_d.fbit = base_bit ^ (is_pat && invert);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fbit = st_q.fbit;
endmodule

// File: rtl/t1fb_checker.sv
module t1fb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic       ch_valid,
    input logic [7:0] ch_data,
    input logic       esf_mode,
    input logic       zs_en,
    input logic       yel_en,
    input logic       yel_fs_style,
    input logic       fbit,
    input logic       out_valid,
    input logic [7:0] out_data
);
    AST_FBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(fbit)); // R1

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |=> out_valid); // R11

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_valid |=> !out_valid); // R11

    AST_YEL_CLEARS_BIT2: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && yel_en && !esf_mode && !yel_fs_style) |=> !out_data[6]); // R9

    AST_ZERO_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && zs_en && ch_data == 8'h00) |=> out_data == 8'h02); // R8

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && !zs_en && !(yel_en && !esf_mode && !yel_fs_style))
        |=> out_data == $past(ch_data)); // R8
endmodule

bind t1_fbit_injector t1fb_checker u_chk (.*);

// File: tb/sim_t1_fbit_injector.sv
`timescale 1ns/1ps
module sim_t1_fbit_injector;
    localparam int PER = 16;

    logic       clk = 0, rst_n = 0;
    logic       frame_start = 0, ch_valid = 0, esf_mode = 0, zs_en = 0;
    logic       yel_en = 0, yel_fs_style = 0, fs_ins_en = 0, burst_ctl = 0, period_ctl = 0;
    logic [7:0] ch_data = 0;
    logic [5:0] fs_pattern = 0;
    logic       fbit, out_valid;
    logic [7:0] out_data;

    int    checks = 0, failures = 0, cycles = 0;
    string cur = "R1";
    bit    running = 0;

    // reference model state
    int   m_frame = 11, m_left = 0, m_pcnt = 0;
    bit   m_prev_esf = 0, m_bprev = 0, m_fbit = 0, m_ov = 0;
    int   m_od = 0;
    int   fs_int[6]  = '{0, 0, 1, 1, 1, 0};
    int   fps_int[6] = '{0, 0, 1, 0, 1, 1};

    t1_fbit_injector #(.PERIOD(PER)) u0 (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_frame = 11; m_left = 0; m_pcnt = 0; m_prev_esf = 0;
            m_bprev = 0; m_fbit = 0; m_ov = 0; m_od = 0;
        end else begin
            int nf, n, f, d;
            bit pat, inv;
            nf = esf_mode ? 24 : 12;
            if (esf_mode != m_prev_esf) m_frame = nf - 1;
            m_prev_esf = esf_mode;
            if (burst_ctl && !m_bprev) m_left = 3;
            m_bprev = burst_ctl;
            if (!period_ctl) m_pcnt = 0;
            if (frame_start) begin
                m_frame = (m_frame + 1) % nf;
                n = m_frame + 1;
                pat = 0; f = 0;
                if (!esf_mode) begin
                    if (n % 2 == 1) begin
                        pat = 1; f = (((n - 1) / 2) % 2 == 0) ? 1 : 0;
                    end else begin
                        f = fs_ins_en ? int'(fs_pattern[n/2-1]) : fs_int[n/2-1];
                        if (yel_en && yel_fs_style && n == 12) f = 1;
                    end
                end else if (n % 4 == 0) begin
                    pat = 1; f = fps_int[n/4-1];
                end
                if (pat) begin
                    inv = 0;
                    if (m_left > 0) begin inv = 1; m_left--; end
                    if (period_ctl) begin
                        if (m_pcnt == 0) inv = 1;
                        m_pcnt = (m_pcnt + 1) % PER;
                    end
                    if (inv) f = 1 - f;
                end
                m_fbit = f[0];
            end
            m_ov = ch_valid;
            if (ch_valid) begin
                d = ch_data;
                if (yel_en && !esf_mode && !yel_fs_style) d = d & 8'hBF;
                if (zs_en && d == 0) d = 8'h02;
                m_od = d;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (running && rst_n) begin
            chk(cur, "fbit", fbit, m_fbit);
            chk("R11", "out_valid", out_valid, m_ov);
            if (m_ov) chk(cur, "out_data", out_data, m_od);
        end
    end

    task automatic run_frames(input int n);
        for (int f = 0; f < n; f++) begin
            @(negedge clk); frame_start = 1; ch_valid = 0;
            @(negedge clk); frame_start = 0;
            for (int b = 0; b < 24; b++) begin
                int r;
                @(negedge clk);
                r = $urandom % 4;
                ch_valid = ($urandom % 5) != 0;
                ch_data  = (r == 0) ? 8'h00 : (r == 1) ? 8'h40 : 8'($urandom);
            end
            @(negedge clk); ch_valid = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset fbit", fbit, 0);
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset out_data", out_data, 0);
        rst_n = 1; running = 1;
        cur = "R2"; run_frames(24);
        cur = "R3"; fs_ins_en = 1; fs_pattern = 6'b101101; run_frames(12);
        fs_pattern = 6'b010011; run_frames(12);
        cur = "R4"; esf_mode = 1; run_frames(30);
        cur = "R3"; run_frames(24); fs_ins_en = 0;
        cur = "R1"; esf_mode = 0; run_frames(5); esf_mode = 1; run_frames(7);
        @(negedge clk); esf_mode = 0; frame_start = 1;
        @(negedge clk); frame_start = 0; run_frames(14);
        cur = "R5"; @(negedge clk); burst_ctl = 1; run_frames(10);
        burst_ctl = 0; @(negedge clk); burst_ctl = 1; run_frames(3);
        burst_ctl = 0; @(negedge clk); burst_ctl = 1; run_frames(9);
        burst_ctl = 0; esf_mode = 1; @(negedge clk); burst_ctl = 1; run_frames(30);
        @(negedge clk); burst_ctl = 0; frame_start = 1;
        @(negedge clk); burst_ctl = 1; frame_start = 1;
        @(negedge clk); frame_start = 0; run_frames(20); burst_ctl = 0;
        cur = "R6"; period_ctl = 1; run_frames(140);
        period_ctl = 0; run_frames(3); period_ctl = 1; esf_mode = 0; run_frames(45);
        cur = "R7"; @(negedge clk); period_ctl = 0; burst_ctl = 0;
        @(negedge clk); period_ctl = 1; burst_ctl = 1; run_frames(40);
        period_ctl = 0; burst_ctl = 0;
        cur = "R8"; zs_en = 1; run_frames(6);
        cur = "R9"; yel_en = 1; run_frames(6);
        cur = "R8"; run_frames(4); zs_en = 0;
        cur = "R10"; yel_fs_style = 1; run_frames(26);
        fs_ins_en = 1; fs_pattern = 6'b000000; run_frames(12);
        esf_mode = 1; yel_fs_style = 0; run_frames(26);
        yel_en = 0; fs_ins_en = 0;
        repeat (4) @(negedge clk);
        running = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        failures++;
        $display("FAIL R1 watchdog actual=%0d expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule